// File: doc/BRIEF.md
# CRC Zero-Run Advance Unit

This unit takes a CRC register value and a byte count `n` and returns the value that register would hold after `n` zero bytes had been shifted through it. It does not clock `8n` zero bits through a shift register. Instead it forms `x^(8n) mod P` by square-and-multiply over the bits of the exponent, starting from `x`. It then multiplies the incoming CRC by that factor, carrylessly and modulo `P`. A single bit-serial carryless multiply-mod-P engine is shared by every step, so the run time grows with the logarithm of `n`, not with `n`.

The intended use is CRC combination for a non-reflected CRC whose register starts at zero and has no final inversion. The CRC of `A` followed by `B` equals the CRC of `A`, advanced over `|B|` zero bytes, XORed with the CRC of `B`. The combination works because zeros shifted into an all-zero register leave it at zero.

A one-cycle `start_i` pulse launches a request. `done_o` goes high together with the result and stays high until the next accepted request.

Top module: `crc_zero_advance`

## Requirements
- R1: After reset, `done_o` is 0 and `crc_o` is 0.
- R2: For `n` > 0 the result equals `crc_i` after `8n` zero-bit shifts. Each shift moves the register left by one (MSB out) and XORs the polynomial 0x04C11DB7 when the bit shifted out was 1.
- R3: For `n` = 0 the result equals `crc_i`, and `done_o` is high in the cycle right after the accepting clock edge.
- R4: An accepted request with `n` > 0 clears `done_o` at the next edge. Once `done_o` is high, `done_o` and `crc_o` keep their values until the next accepted request.
- R5: `done_o` rises no more than (CNT_W+3)·(2·CRC_W+3)+CRC_W+4 cycles after the accepting edge.
- R6: A zero `crc_i` gives a zero result, and the latency is the same as for a nonzero `crc_i` with the same `n`.
- R7: With zero-start CRCs, the advanced CRC(A) over |B| bytes, XORed with CRC(B), equals CRC(A then B).
- R8: The CRC of 32 data bytes, advanced over 992 zero bytes, equals the CRC of the whole 1024-byte buffer.
- R9: A `start_i` pulse that arrives while a request is in progress is ignored, and the running request completes with its own result.
- R10: The largest count, `n` = 65535, is advanced correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request strobe, accepted only while idle or done |
| crc_i | input | CRC_W (32) | CRC value to be advanced |
| nbytes_i | input | CNT_W (16) | Number of zero bytes to skip over |
| crc_o | output | CRC_W (32) | Advanced CRC |
| done_o | output | 1 | Result valid, held until the next accepted request |

## Verification
The bench builds the unit with its defaults: a 32-bit CRC, polynomial 0x04C11DB7 and a 16-bit byte count. The 16-bit count makes the full 19-bit exponent reachable. At `n` = 65535 every exponent bit above the three low zeros is 1, so that case takes the longest multiply chain and the worst-case latency. The same defaults allow the bench to compare against a bitwise CRC of a 1024-byte buffer and against a two-part message combined from its halves.

// File: rtl/crc_adv_pkg.sv
package crc_adv_pkg;

    // Sequencer states of the zero-run advance unit
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STEP,
        ST_MULP,
        ST_SQR,
        ST_FIN,
        ST_DONE
    } adv_state_e;

    // Operand pair handed to the shared multiplier
    typedef struct packed {
        logic        go;
        logic [31:0] a;
        logic [31:0] b;
    } mul_req_t;

    // Worst-case cycle count from an accepted request to done
    function automatic int lat_max(input int crc_w, input int cnt_w);
        return (cnt_w + 3) * (2 * crc_w + 3) + crc_w + 4;
    endfunction

endpackage

// File: rtl/crc_clmul_mod.sv
module crc_clmul_mod #(
    parameter int          W    = 32,
    parameter logic [W-1:0] POLY = 32'h04C11DB7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] res_o,
    output logic         valid_o
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  acc_q, a_q, b_q;
    logic [CW-1:0] cnt_q;
    logic          busy_q;
    logic [W-1:0]  acc_sh;

    // one step: multiply partial product by x, reduce, add a when b bit set
    always_comb begin
        acc_sh = {acc_q[W-2:0], 1'b0} ^ (acc_q[W-1] ? POLY : '0);
        if (b_q[W-1]) acc_sh = acc_sh ^ a_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= '0;
            a_q     <= '0;
            b_q     <= '0;
            cnt_q   <= '0;
            busy_q  <= 1'b0;
            valid_o <= 1'b0;
        end else if (start_i) begin
            acc_q   <= '0;
            a_q     <= a_i;
            b_q     <= b_i;
            cnt_q   <= CW'(W);
            busy_q  <= 1'b1;
            valid_o <= 1'b0;
        end else if (busy_q) begin
            acc_q <= acc_sh;
            b_q   <= {b_q[W-2:0], 1'b0};
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CW'(1)) begin
                busy_q  <= 1'b0;
                valid_o <= 1'b1;
            end
        end else begin
            valid_o <= 1'b0;
        end
    end

    assign res_o = acc_q;

    // R2
    mul_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

endmodule

// File: rtl/crc_exp_reg.sv
module crc_exp_reg #(
    parameter int EW = 19
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_i,
    input  logic [EW-1:0] val_i,
    input  logic          shift_i,
    output logic          lsb_o,
    output logic          rest_nz_o,
    output logic          nz_o
);
    logic [EW-1:0] e_q;

    always_ff @(posedge clk) begin
        if (rst)          e_q <= '0;
        else if (load_i)  e_q <= val_i;
        else if (shift_i) e_q <= {1'b0, e_q[EW-1:1]};
    end

    assign lsb_o     = e_q[0];
    assign rest_nz_o = |e_q[EW-1:1];
    assign nz_o      = |e_q;

endmodule

// File: rtl/crc_zero_advance.sv
module crc_zero_advance
    import crc_adv_pkg::*;
#(
    parameter int              CRC_W = 32,
    parameter int              CNT_W = 16,
    parameter logic [CRC_W-1:0] POLY = 32'h04C11DB7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [CRC_W-1:0] crc_i,
    input  logic [CNT_W-1:0] nbytes_i,
    output logic [CRC_W-1:0] crc_o,
    output logic             done_o
);
    localparam int EW   = CNT_W + 3;
    localparam int LMAX = lat_max(CRC_W, CNT_W);
    localparam int LW   = $clog2(LMAX + 2) + 1;

    adv_state_e       state_q;
    logic [CRC_W-1:0] prod_q, sq_q, crc_q;
    logic             accept;
    logic             e_lsb, e_rest, e_nz, e_shift;
    logic             m_go, m_valid;
    logic [CRC_W-1:0] m_a, m_b, m_res;

    assign accept = start_i && (state_q == ST_IDLE || state_q == ST_DONE);

    crc_exp_reg #(.EW(EW)) exp_i (
        .clk      (clk),
        .rst      (rst),
        .load_i   (accept && (nbytes_i != '0)),
        .val_i    ({nbytes_i, 3'b000}),
        .shift_i  (e_shift),
        .lsb_o    (e_lsb),
        .rest_nz_o(e_rest),
        .nz_o     (e_nz)
    );

    crc_clmul_mod #(.W(CRC_W), .POLY(POLY)) mul_i (
        .clk    (clk),
        .rst    (rst),
        .start_i(m_go),
        .a_i    (m_a),
        .b_i    (m_b),
        .res_o  (m_res),
        .valid_o(m_valid)
    );

    // operand selection for the shared multiplier
    always_comb begin
        m_go    = 1'b0;
        m_a     = sq_q;
        m_b     = sq_q;
        e_shift = 1'b0;
        unique case (state_q)
            ST_STEP: begin
                m_go = 1'b1;
                if (!e_nz) begin
                    m_a = crc_q;
                    m_b = prod_q;
                end else if (e_lsb) begin
                    m_a = prod_q;
                    m_b = sq_q;
                end
            end
            ST_MULP: begin
                if (m_valid && e_rest) m_go = 1'b1;
                if (m_valid && !e_rest) e_shift = 1'b1;
            end
            ST_SQR:  e_shift = m_valid;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            prod_q  <= '0;
            sq_q    <= '0;
            crc_q   <= '0;
            crc_o   <= '0;
            done_o  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_DONE: begin
                    if (accept) begin
                        if (nbytes_i == '0) begin
                            crc_o   <= crc_i;
                            done_o  <= 1'b1;
                            state_q <= ST_DONE;
                        end else begin
                            prod_q  <= CRC_W'(1);
                            sq_q    <= CRC_W'(2);
                            crc_q   <= crc_i;
                            done_o  <= 1'b0;
                            state_q <= ST_STEP;
                        end
                    end
                end
                ST_STEP: begin
                    if (!e_nz)      state_q <= ST_FIN;
                    else if (e_lsb) state_q <= ST_MULP;
                    else            state_q <= ST_SQR;
                end
                ST_MULP: begin
                    if (m_valid) begin
                        prod_q  <= m_res;
                        state_q <= e_rest ? ST_SQR : ST_STEP;
                    end
                end
                ST_SQR: begin
                    if (m_valid) begin
                        sq_q    <= m_res;
                        state_q <= ST_STEP;
                    end
                end
                ST_FIN: begin
                    if (m_valid) begin
                        crc_o   <= m_res;
                        done_o  <= 1'b1;
                        state_q <= ST_DONE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // latency watch used by the bound check below
    logic [LW-1:0] lat_q;
    always_ff @(posedge clk) begin
        if (rst || accept) lat_q <= '0;
        else if (state_q != ST_IDLE && state_q != ST_DONE) lat_q <= lat_q + 1'b1;
    end

    // R4
    done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && !start_i) |=> (done_o && $stable(crc_o)));

    // R4
    done_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && nbytes_i != '0) |=> !done_o);

    // R3
    zero_len_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && nbytes_i == '0) |=> (done_o && crc_o == $past(crc_i)));

    // R5
    latency_bound_chk: assert property (@(posedge clk) disable iff (rst)
        lat_q <= LW'(LMAX));

endmodule

// File: tb/crc_zero_advance_tb_top.sv
module crc_zero_advance_tb_top;
    localparam logic [31:0] P = 32'h04C11DB7;
    localparam int LBOUND = (16 + 3) * (2 * 32 + 3) + 32 + 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [31:0] crc_i = '0;
    logic [15:0] nbytes_i = '0;
    logic [31:0] crc_o;
    logic        done_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    logic [7:0] mem [0:1023];

    always #2.5 clk = ~clk;

    crc_zero_advance dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .crc_i(crc_i),
        .nbytes_i(nbytes_i), .crc_o(crc_o), .done_o(done_o)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, expv);
        end
    endtask

    function automatic logic [31:0] ref_adv(input logic [31:0] c, input int n);
        logic [31:0] r = c;
        for (int i = 0; i < n * 8; i++) r = r[31] ? ((r << 1) ^ P) : (r << 1);
        return r;
    endfunction

    function automatic logic [31:0] ref_crc(input int first, input int len);
        logic [31:0] r = '0;
        for (int i = first; i < first + len; i++) begin
            r = r ^ {mem[i], 24'h0};
            for (int k = 0; k < 8; k++) r = r[31] ? ((r << 1) ^ P) : (r << 1);
        end
        return r;
    endfunction

    task automatic run(input logic [31:0] c, input logic [15:0] n, output logic [31:0] got, output int lat);
        @(negedge clk);
        start_i = 1'b1; crc_i = c; nbytes_i = n;
        @(negedge clk);
        start_i = 1'b0;
        lat = 1;
        if (n != 0) check(done_o == 1'b0, "R4 done cleared", 32'(done_o), 32'd0);
        while (!done_o && lat < 4000) begin
            @(negedge clk);
            lat++;
        end
        got = crc_o;
        check(lat <= LBOUND, "R5 latency", 32'(lat), 32'(LBOUND));
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                check(1'b0, "watchdog", 32'(cyc), 32'd150000);
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        logic [31:0] got, got2, expv, ca, cb;
        int lat, lat2;
        for (int i = 0; i < 1024; i++) mem[i] = (i < 32) ? 8'((i * 73 + 19) ^ (i >> 1)) : 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(done_o == 1'b0, "R1 done after reset", 32'(done_o), 32'd0);
        check(crc_o == 32'h0, "R1 crc after reset", crc_o, 32'h0);

        // R3 zero count
        run(32'hDEADBEEF, 16'd0, got, lat);
        check(got == 32'hDEADBEEF, "R3 value", got, 32'hDEADBEEF);
        check(lat == 1, "R3 timing", 32'(lat), 32'd1);

        // R2 several counts and patterns
        run(32'h80000000, 16'd1, got, lat);
        expv = ref_adv(32'h80000000, 1);
        check(got == expv, "R2 n=1", got, expv);
        run(32'h12345678, 16'd4, got, lat);
        expv = ref_adv(32'h12345678, 4);
        check(got == expv, "R2 n=4", got, expv);
        run(32'hFFFFFFFF, 16'd5, got, lat);
        expv = ref_adv(32'hFFFFFFFF, 5);
        check(got == expv, "R2 n=5", got, expv);
        run(32'h00000001, 16'd300, got, lat);
        expv = ref_adv(32'h00000001, 300);
        check(got == expv, "R2 n=300", got, expv);

        // R4 hold after done
        repeat (5) @(negedge clk);
        check(done_o == 1'b1 && crc_o == expv, "R4 hold", crc_o, expv);

        // R10 maximum count
        run(32'hA5A5C3C3, 16'hFFFF, got, lat);
        expv = ref_adv(32'hA5A5C3C3, 65535);
        check(got == expv, "R10 n=65535", got, expv);

        // R6 zero input, same latency
        run(32'h0, 16'd77, got, lat);
        run(32'h00001234, 16'd77, got2, lat2);
        check(got == 32'h0, "R6 zero result", got, 32'h0);
        check(lat == lat2, "R6 latency equal", 32'(lat), 32'(lat2));
        expv = ref_adv(32'h00001234, 77);
        check(got2 == expv, "R2 n=77", got2, expv);

        // R7 combine: A = mem[0..9], B = mem[10..31]
        ca = ref_crc(0, 10);
        cb = ref_crc(10, 22);
        run(ca, 16'd22, got, lat);
        expv = ref_crc(0, 32);
        check((got ^ cb) == expv, "R7 combine", got ^ cb, expv);

        // R8 32 data bytes plus 992 zeros
        run(ref_crc(0, 32), 16'd992, got, lat);
        expv = ref_crc(0, 1024);
        check(got == expv, "R8 padded buffer", got, expv);

        // R9 start while busy is ignored
        @(negedge clk);
        start_i = 1'b1; crc_i = 32'hCAFEF00D; nbytes_i = 16'd200;
        @(negedge clk);
        start_i = 1'b0;
        repeat (20) @(negedge clk);
        start_i = 1'b1; crc_i = 32'h11111111; nbytes_i = 16'd0;
        @(negedge clk);
        start_i = 1'b0;
        check(done_o == 1'b0, "R9 no early done", 32'(done_o), 32'd0);
        lat = 0;
        while (!done_o && lat < 4000) begin
            @(negedge clk);
            lat++;
        end
        expv = ref_adv(32'hCAFEF00D, 200);
        check(crc_o == expv, "R9 original result", crc_o, expv);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule